// File: doc/BRIEF.md
# Dual-Edge Slow-Clock Phase Tracker

This block finds where the rising edges of a slow clock land relative to a faster clock. Both clocks come from one generator, so their edges keep a fixed relationship. The slow clock period is an odd number of fast half-cycles; the default is seven, a ratio of 3.5. As a result, consecutive slow rising edges alternate between lining up with a fast rising edge and lining up with a fast falling edge.

In the slow domain, one flop flips its state on every slow rising edge. The fast domain samples that flop twice per fast cycle, once on each fast clock edge. Because the clock phases are fixed, no extra synchronizer stages follow these two samplers. For each slow edge, the block checks which half of the fast cycle the change appeared in. It then raises one of two one-cycle markers, so a downstream serializer knows where to place its first bit.

A lock flag follows the markers. It rises once the markers have alternated with exactly the expected spacing for a configurable number of consecutive periods. It falls on the first marker that arrives out of place, or when a marker that is due does not arrive. Elaboration stops if the half-cycle count is even or below three, or if the required run count is zero.

Top module: `edge_phase_tracker`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first slow rising edge, `mark_rise_o`, `mark_fall_o` and `locked_o` are all low.
- R2: A slow rising edge that lands in the first half of a fast cycle (after a fast rising edge, before the next fast falling edge) drives `mark_rise_o` high. The pulse starts at the second fast rising edge after the slow edge and lasts exactly one fast cycle. `mark_fall_o` stays low.
- R3: A slow rising edge that lands in the second half of a fast cycle (after a fast falling edge, before the next fast rising edge) drives `mark_fall_o` high. The pulse starts at the second fast rising edge after the slow edge and lasts exactly one fast cycle. `mark_rise_o` stays low.
- R4: The two markers are never high together, and neither stays high for two consecutive fast cycles. With the slow clock running continuously at the default ratio, every slow edge yields exactly one marker, and the marker types alternate.
- R5: A period is good when two rise markers are exactly `HALF_CYCLES_PER_SLOW` fast cycles apart (7 by default) and exactly one fall marker comes between them, `(HALF_CYCLES_PER_SLOW-1)/2` cycles after the first (3 by default). `locked_o` rises after `LOCK_RUNS` consecutive good periods (default 4) and not earlier.
- R6: A marker that arrives out of place drops `locked_o` on the next fast cycle and restarts the count of good periods. Examples are a fall marker at the wrong spacing or a second fall marker within one period.
- R7: When the slow clock stops, no markers are produced. `locked_o` drops once `HALF_CYCLES_PER_SLOW` fast cycles pass after a rise marker without the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock; both of its edges sample the slow-domain flop |
| clk_slow_i | input | 1 | Slow clock, from the same generator as the fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| mark_rise_o | output | 1 | One-cycle pulse: slow edge landed in the first half of a fast cycle |
| mark_fall_o | output | 1 | One-cycle pulse: slow edge landed in the second half of a fast cycle |
| locked_o | output | 1 | High while the marker pattern keeps its expected spacing |

## Verification
The hardest case to reach from the ports is a lock that is already established and then broken by a single misplaced slow edge. The edge must land so that it produces a plausible marker of the wrong type, instead of simply disappearing. The bench drives the slow clock itself, with half-nanosecond offsets from the fast edges. It runs a long train until lock holds, then stretches one low phase by half a fast cycle. That moves every later slow edge into the other half of its fast cycle, so an extra fall marker appears where a rise marker was due. Separate single-edge pulses, placed in each half of a fast cycle, pin down the latency and the type of each marker.

// File: rtl/ept_pkg.sv
package ept_pkg;

   typedef struct packed {
      logic rise;   // slow edge resolved into the first half of a fast cycle
      logic fall;   // slow edge resolved into the second half of a fast cycle
   } ept_mark_t;

endpackage

// File: rtl/ept_toggle.sv
module ept_toggle (
   input  logic clk_slow_i,
   input  logic rst_ni,
   output logic tog_o
);

   always_ff @(posedge clk_slow_i or negedge rst_ni) begin
      if (!rst_ni) tog_o <= 1'b0;
      else         tog_o <= ~tog_o;
   end

endmodule

// File: rtl/ept_sampler.sv
module ept_sampler #(
   parameter bit MARK_REG = 1'b1
) (
   input  logic                clk_fast_i,
   input  logic                rst_ni,
   input  logic                tog_i,
   output ept_pkg::ept_mark_t  mark_o
);

   logic rise_smp_q, rise_hist_q, fall_smp_q, fall_hold_q;
   logic changed, early_half;
   ept_pkg::ept_mark_t mark_c;

   // The falling-edge sampler sits between two rising-edge samples.
   always_ff @(negedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) fall_smp_q <= 1'b0;
      else         fall_smp_q <= tog_i;
   end

   always_ff @(posedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_smp_q  <= 1'b0;
         rise_hist_q <= 1'b0;
         fall_hold_q <= 1'b0;
      end else begin
         rise_smp_q  <= tog_i;
         rise_hist_q <= rise_smp_q;
         fall_hold_q <= fall_smp_q;
      end
   end

   // When the falling sample already shows the new level, the slow edge
   // came before the middle of the fast cycle.
   assign changed     = rise_smp_q ^ rise_hist_q;
   assign early_half  = (fall_hold_q == rise_smp_q);
   assign mark_c.rise = changed &  early_half;
   assign mark_c.fall = changed & ~early_half;

   if (MARK_REG) begin : g_reg_mark
      always_ff @(posedge clk_fast_i or negedge rst_ni) begin
         if (!rst_ni) mark_o <= '0;
         else         mark_o <= mark_c;
      end
   end else begin : g_comb_mark
      assign mark_o = mark_c;
   end

   p_marks_exclusive_r4: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      !(mark_o.rise && mark_o.fall));
   p_rise_single_r4: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      mark_o.rise |=> !mark_o.rise);
   p_fall_single_r4: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      mark_o.fall |=> !mark_o.fall);

endmodule

// File: rtl/ept_lock.sv
module ept_lock #(
   parameter int HALF_CYCLES_PER_SLOW = 7,
   parameter int LOCK_RUNS            = 4
) (
   input  logic                clk_fast_i,
   input  logic                rst_ni,
   input  ept_pkg::ept_mark_t  mark_i,
   output logic                locked_o
);

   localparam int PAIR_CYC = HALF_CYCLES_PER_SLOW;
   localparam int FALL_OFS = (HALF_CYCLES_PER_SLOW - 1) / 2;
   localparam int CNT_W    = $clog2(PAIR_CYC + 1);
   localparam int RUN_W    = $clog2(LOCK_RUNS + 1);
   localparam logic [CNT_W-1:0] CNT_PAIR = CNT_W'(PAIR_CYC);
   localparam logic [CNT_W-1:0] CNT_FALL = CNT_W'(FALL_OFS);
   localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUNS);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUNS - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;      // 0: no reference rise marker yet
   logic             seen_q, seen_d;
   logic [RUN_W-1:0] runs_q;
   logic             good, bad;

   always_comb begin
      cnt_d  = cnt_q;
      seen_d = seen_q;
      good   = 1'b0;
      bad    = 1'b0;
      if (cnt_q == '0) begin
         if (mark_i.rise) begin
            cnt_d  = CNT_W'(1);
            seen_d = 1'b0;
         end
      end else if (mark_i.rise) begin
         cnt_d  = CNT_W'(1);
         seen_d = 1'b0;
         if (cnt_q == CNT_PAIR && seen_q) good = 1'b1;
         else                             bad  = 1'b1;
      end else if (mark_i.fall) begin
         if (cnt_q == CNT_FALL && !seen_q) begin
            seen_d = 1'b1;
            cnt_d  = cnt_q + CNT_W'(1);
         end else begin
            bad    = 1'b1;
            cnt_d  = '0;
            seen_d = 1'b0;
         end
      end else if (cnt_q == CNT_PAIR) begin
         bad   = 1'b1;
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         seen_q   <= 1'b0;
         runs_q   <= '0;
         locked_o <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         seen_q <= seen_d;
         if (bad) begin
            runs_q   <= '0;
            locked_o <= 1'b0;
         end else if (good) begin
            if (runs_q != RUN_MAX) runs_q <= runs_q + RUN_W'(1);
            if (runs_q >= RUN_LAST) locked_o <= 1'b1;
         end
      end
   end

   p_lock_on_rise_r5: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(mark_i.rise));
   p_bad_fall_drops_r6: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      (mark_i.fall && !mark_i.rise && cnt_q != '0 && (cnt_q != CNT_FALL || seen_q))
      |=> !locked_o);
   p_overdue_drops_r7: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      (cnt_q == CNT_PAIR && !mark_i.rise) |=> !locked_o);

endmodule

// File: rtl/edge_phase_tracker.sv
module edge_phase_tracker #(
   parameter int HALF_CYCLES_PER_SLOW = 7,
   parameter int LOCK_RUNS            = 4,
   parameter bit MARK_REG             = 1'b1
) (
   input  logic clk_fast_i,
   input  logic clk_slow_i,
   input  logic rst_ni,
   output logic mark_rise_o,
   output logic mark_fall_o,
   output logic locked_o
);

   if (HALF_CYCLES_PER_SLOW < 3 || (HALF_CYCLES_PER_SLOW % 2) == 0) begin : g_bad_ratio
      $error("HALF_CYCLES_PER_SLOW must be odd and at least 3");
   end
   if (LOCK_RUNS < 1) begin : g_bad_runs
      $error("LOCK_RUNS must be at least 1");
   end

   logic               tog;
   ept_pkg::ept_mark_t mark;

   ept_toggle i_toggle (
      .clk_slow_i (clk_slow_i),
      .rst_ni     (rst_ni),
      .tog_o      (tog)
   );

   ept_sampler #(
      .MARK_REG (MARK_REG)
   ) i_sampler (
      .clk_fast_i (clk_fast_i),
      .rst_ni     (rst_ni),
      .tog_i      (tog),
      .mark_o     (mark)
   );

   ept_lock #(
      .HALF_CYCLES_PER_SLOW (HALF_CYCLES_PER_SLOW),
      .LOCK_RUNS            (LOCK_RUNS)
   ) i_lock (
      .clk_fast_i (clk_fast_i),
      .rst_ni     (rst_ni),
      .mark_i     (mark),
      .locked_o   (locked_o)
   );

   assign mark_rise_o = mark.rise;
   assign mark_fall_o = mark.fall;

endmodule

// File: tb/test_edge_phase_tracker.sv
module test_edge_phase_tracker;
   timeunit 1ns;
   timeprecision 100ps;

   logic clk_f = 1'b0;
   logic clk_s = 1'b0;
   logic rst_n = 1'b0;
   logic mr, mf, lk;

   int n_checks = 0;
   int n_errors = 0;
   int cnt_r = 0;
   int cnt_f = 0;
   int viol  = 0;
   bit prev_r = 1'b0;
   bit prev_f = 1'b0;

   always #2 clk_f = ~clk_f;   // 250 MHz

   edge_phase_tracker i_edge_phase_tracker (
      .clk_fast_i  (clk_f),
      .clk_slow_i  (clk_s),
      .rst_ni      (rst_n),
      .mark_rise_o (mr),
      .mark_fall_o (mf),
      .locked_o    (lk)
   );

   // marker monitor, sampled mid-cycle (R4)
   always @(negedge clk_f) begin
      if (rst_n) begin
         if (mr) cnt_r++;
         if (mf) cnt_f++;
         if ((mr && mf) || (mr && prev_r) || (mf && prev_f)) viol++;
         prev_r = mr;
         prev_f = mf;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk_f);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk_f);
      #1;
      check(!mr && !mf && !lk, "R1 in reset", {mr, mf, lk}, 0);
      @(negedge clk_f);
      rst_n = 1'b1;
      idle(4);
      check(!mr && !mf && !lk, "R1 after release", {mr, mf, lk}, 0);
   endtask

   // one slow edge, placed 0.5 ns (first half) or 2.5 ns (second half) after a fast rise
   task automatic t_single(input bit late);
      string rq;
      rq = late ? "R3" : "R2";
      @(posedge clk_f);
      #(late ? 2.5 : 0.5);
      clk_s = 1'b1;
      @(posedge clk_f);
      #1;
      check(!mr && !mf, {rq, " before latency"}, {mr, mf}, 0);
      @(posedge clk_f);
      #1;
      check(late ? (mf && !mr) : (mr && !mf), {rq, " marker type"}, {mr, mf}, late ? 1 : 2);
      @(posedge clk_f);
      #1;
      check(!mr && !mf, {rq, " one-cycle pulse"}, {mr, mf}, 0);
      clk_s = 1'b0;
      idle(12);
   endtask

   // continuous slow clock (14 ns period); edge stretch_k is delayed by 2 ns
   task automatic train(input int n, input int stretch_k);
      @(posedge clk_f);
      #0.5;
      for (int k = 0; k < n; k++) begin
         if (k == stretch_k) begin
            check(lk == 1'b1, "R6 locked before deviation", lk, 1);
            #2;
         end
         clk_s = 1'b1;
         #7;
         clk_s = 1'b0;
         #7;
      end
   endtask

   task automatic t_lock_full();
      int r0, f0;
      r0 = cnt_r;
      f0 = cnt_f;
      train(14, -1);
      #0.1;
      check(lk == 1'b1, "R5 lock after long train", lk, 1);
      check(cnt_r - r0 == 7, "R4 rise marker count", cnt_r - r0, 7);
      check(cnt_f - f0 == 7, "R4 fall marker count", cnt_f - f0, 7);
      r0 = cnt_r;
      f0 = cnt_f;
      idle(12);
      check(lk == 1'b0, "R7 lock drops when slow clock stops", lk, 0);
      check(cnt_r == r0 && cnt_f == f0, "R7 no markers while stopped",
            (cnt_r - r0) + (cnt_f - f0), 0);
   endtask

   task automatic t_lock_short();
      train(7, -1);
      #0.1;
      check(lk == 1'b0, "R5 no lock after three good periods", lk, 0);
      idle(12);
   endtask

   task automatic t_deviate();
      train(20, 16);
      #0.1;
      check(lk == 1'b0, "R6 lock lost after shifted edge", lk, 0);
      idle(12);
   endtask

   initial begin
      #100us;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      t_reset();
      t_single(1'b0);
      t_single(1'b1);
      t_lock_full();
      t_lock_short();
      t_deviate();
      check(viol == 0, "R4 overlap or stretched marker", viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule